// File: doc/BRIEF.md
# Two-wire serial EEPROM slave

This block models a small byte-wide nonvolatile memory that sits as a slave on a two-wire serial bus. It lives in a fast system clock domain. It oversamples the bus clock and data lines through a short synchronizer. From those samples it finds the bus START and STOP conditions, the clock rising and falling edges, and the bits of each byte. The data line is open-drain, so the block only ever asks for it to be pulled low.

A master selects the slave with a device address byte. The slave answers only when that byte matches a fixed 4-bit family code and the three strap pins. A write sequence first sets the internal word pointer and may then load up to one page of data bytes. Those bytes are held in a page buffer. They reach the array only on the STOP that ends the transaction, and the STOP also starts a timed busy window. While that window runs, the slave ignores its own address. A read sequence streams bytes out from the word pointer; combined with a pointer-setting write and a repeated START, it gives a random read. A write-protect input, sampled at STOP, stops any commit.

Top module: `twowire_nvm_slave`

## Requirements
- R1: The array holds 2^AW bytes (256 by default). Every byte can be written and read back at its own 8-bit word address.
- R2: The device address byte is sent MSB first as 1010, then three strap bits, then the direction bit (1 = read). The slave acknowledges only when bits 7:4 equal 1010 and bits 3:1 equal `strap`. Any other value gets no acknowledge, and the line stays released until the next START.
- R3: Incoming bits are sampled on the rising edge of the bus clock. The slave changes its pull on the data line only after a falling edge of the bus clock, never while the clock is high.
- R4: The data line is only pulled low or released. Out of reset, after a master NACK and while idle, the line is released.
- R5: A write loads 1 to 8 data bytes into the page that holds the word pointer. The low 3 address bits wrap inside that page, so a byte past the page end lands at the start of the same page. Bytes not sent keep their old contents.
- R6: If `wp` is high at the STOP that ends a write, the data bytes are still acknowledged, but the array does not change and no busy window starts.
- R7: A STOP that ends a write with at least one data byte starts a busy window of WR_CYCLES system clocks. A STOP after only a word address starts no busy window.
- R8: While the busy window runs, the slave does not acknowledge its device address.
- R9: A random read works as follows: a write of the word address, then a repeated START and a read address byte. The first byte returned comes from that word address.
- R10: In a read, each master acknowledge makes the slave send the next byte, and the pointer wraps from the top address to 0. A master NACK ends the read and releases the line.
- R11: A current-address read with no word address starts at the address after the last byte read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the wire |
| sda_i | input | 1 | Bus data line as seen on the wire (includes the slave's own pull) |
| strap | input | 3 | Hard-wired device address bits compared with bits 3:1 of the address byte |
| wp | input | 1 | Write protect; high blocks every commit to the array |
| sda_pull | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
A wrong bit counter or state shows up at the port within one byte. The acknowledge slot moves or goes missing, and the master sees it on the ninth clock of that same byte. A bad word pointer or bad page wrap shows no symptom at write time. It appears only when the affected bytes are read back, after the busy window ends. So every written location is read back in one long sequential read that crosses the top-address wrap. A busy counter of the wrong length shows up as an acknowledge, or a missing one, when the device address is polled right after STOP and again after the window.

// File: rtl/twowire_nvm_slave.sv
module twowire_nvm_slave #(
  parameter int AW        = 8,
  parameter int PW        = 3,
  parameter int WR_CYCLES = 5000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic [2:0]    strap,
  input  logic          wp,
  output logic          sda_pull
);
  localparam int DEPTH = 1 << AW;
  localparam int PAGE  = 1 << PW;
  localparam int CW    = $clog2(WR_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_WADDR, S_WDATA, S_RDATA} st_t;

  logic [7:0]      mem  [DEPTH];
  logic [7:0]      pbuf [PAGE];
  logic [PAGE-1:0] pmask;
  logic [1:0]      scl_sy, sda_sy;
  logic            scl_q, sda_q;
  st_t             st;
  logic [3:0]      bcnt;
  logic [7:0]      rx, tx;
  logic [AW-1:0]   addr;
  logic            rw, mack;
  logic [CW-1:0]   cnt;

  logic scl_s, sda_s, rise, fall, start_det, stop_det;
  logic busy, dev_hit, commit, in_idle, in_dev;

  assign scl_s     = scl_sy[1];
  assign sda_s     = sda_sy[1];
  assign rise      = scl_s & ~scl_q;
  assign fall      = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  assign busy      = cnt != '0;
  assign dev_hit   = rx[7:4] == 4'b1010 && rx[3:1] == strap && !busy;
  assign commit    = st == S_WDATA && pmask != '0 && !wp;
  assign in_idle   = st == S_IDLE;
  assign in_dev    = st == S_DEV;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st       <= S_IDLE;
      bcnt     <= '0;
      rx       <= '0;
      tx       <= '0;
      sda_pull <= 1'b0;
      addr     <= '0;
      rw       <= 1'b0;
      mack     <= 1'b0;
      pmask    <= '0;
      cnt      <= '0;
    end else begin
      if (busy) cnt <= cnt - 1'b1;
      if (start_det) begin
        st       <= S_DEV;
        bcnt     <= '0;
        sda_pull <= 1'b0;
        pmask    <= '0;
      end else if (stop_det) begin
        st       <= S_IDLE;
        bcnt     <= '0;
        sda_pull <= 1'b0;
        pmask    <= '0;
        if (commit) cnt <= CW'(WR_CYCLES);
      end else if (st == S_RDATA) begin
        if (rise && bcnt == 4'd8) mack <= ~sda_s;
        if (fall) begin
          if (bcnt < 4'd7) begin
            tx       <= {tx[6:0], 1'b0};
            sda_pull <= ~tx[6];
            bcnt     <= bcnt + 1'b1;
          end else if (bcnt == 4'd7) begin
            sda_pull <= 1'b0;
            bcnt     <= 4'd8;
          end else if (mack) begin
            tx       <= mem[addr];
            sda_pull <= ~mem[addr][7];
            addr     <= addr + 1'b1;
            bcnt     <= '0;
          end else begin
            st <= S_IDLE;
          end
        end
      end else if (st != S_IDLE) begin
        if (rise && bcnt < 4'd8) begin
          rx   <= {rx[6:0], sda_s};
          bcnt <= bcnt + 1'b1;
        end
        if (fall && bcnt == 4'd8) begin
          bcnt <= 4'd9;
          case (st)
            S_DEV:
              if (dev_hit) begin
                sda_pull <= 1'b1;
                rw       <= rx[0];
              end else begin
                st <= S_IDLE;
              end
            S_WADDR: begin
              addr     <= rx[AW-1:0];
              sda_pull <= 1'b1;
            end
            S_WDATA: begin
              sda_pull              <= 1'b1;
              pmask[addr[PW-1:0]]   <= 1'b1;
              addr[PW-1:0]          <= addr[PW-1:0] + 1'b1;
            end
            default: ;
          endcase
        end
        if (fall && bcnt == 4'd9) begin
          sda_pull <= 1'b0;
          bcnt     <= '0;
          case (st)
            S_DEV:
              if (rw) begin
                st       <= S_RDATA;
                tx       <= mem[addr];
                sda_pull <= ~mem[addr][7];
                addr     <= addr + 1'b1;
              end else begin
                st <= S_WADDR;
              end
            S_WADDR: st <= S_WDATA;
            default: ;
          endcase
        end
      end
    end

  always_ff @(posedge clk) begin
    if (st == S_WDATA && fall && bcnt == 4'd8) pbuf[addr[PW-1:0]] <= rx;
    if (stop_det && commit)
      for (int i = 0; i < PAGE; i++)
        if (pmask[i]) mem[{addr[AW-1:PW], PW'(i)}] <= pbuf[i];
  end
endmodule

// File: rtl/twowire_nvm_slave_chk.sv
module twowire_nvm_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic sda_pull,
  input logic busy,
  input logic wp,
  input logic stop_det,
  input logic in_idle,
  input logic in_dev
);
  AST_PULL_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pull != $past(sda_pull)) |-> !$past(scl_s)); // R3

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle |-> !sda_pull); // R4

  AST_WP_NO_PROG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(wp)); // R6

  AST_PROG_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_det)); // R7

  AST_BUSY_NACK: assert property (@(posedge clk) disable iff (!rst_n)
    (in_dev && busy) |-> !sda_pull); // R8
endmodule

bind twowire_nvm_slave twowire_nvm_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_pull(sda_pull), .busy(busy),
  .wp(wp), .stop_det(stop_det), .in_idle(in_idle), .in_dev(in_dev)
);

// File: tb/twowire_nvm_slave_test.sv
module twowire_nvm_slave_test;
  localparam int Q     = 4;
  localparam int WRC   = 300;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] DEVW = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] DEVR = {4'b1010, STRAP, 1'b1};

  logic clk = 1'b0, rst_n = 1'b0, m_scl = 1'b1, m_sda = 1'b1, wp = 1'b0;
  logic sda_pull, sda_line;
  int   tests = 0, fails = 0, r3_viol = 0;
  bit   done = 1'b0;

  always #5 clk = ~clk;
  assign sda_line = m_sda & ~sda_pull;

  twowire_nvm_slave #(.AW(8), .PW(3), .WR_CYCLES(WRC)) uut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .strap(STRAP), .wp(wp), .sda_pull(sda_pull));

  logic prev_pull = 1'b0;
  always @(negedge clk) begin
    if (rst_n && sda_pull != prev_pull && m_scl) r3_viol++;
    prev_pull = sda_pull;
  end

  function automatic logic [7:0] f(int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bstart();
    m_sda = 1'b1; q(); m_scl = 1'b1; q(); m_sda = 1'b0; q(); m_scl = 1'b0; q();
  endtask

  task automatic bstop();
    m_sda = 1'b0; q(); m_scl = 1'b1; q(); m_sda = 1'b1; q();
  endtask

  task automatic clk_bit(input logic b, output logic s);
    m_sda = b; q(); m_scl = 1'b1; q(); s = sda_line; q(); m_scl = 1'b0; q();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    ack = !s;
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      d[i] = s;
    end
    clk_bit(!give_ack, s);
  endtask

  task automatic set_ptr_read(input logic [7:0] a);
    bit ak;
    bstart(); send_byte(DEVW, ak); send_byte(a, ak);
    bstart(); send_byte(DEVR, ak);
    chk(ak, "R9", ak, 1);
  endtask

  initial begin
    bit ak, okall;
    logic [7:0] d;
    int exp;
    repeat (3) @(negedge clk);
    chk(sda_pull == 1'b0, "R4", sda_pull, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int n = 0; n < 16; n++)
      for (int a = 0; a < 8; a++) begin
        bstart();
        send_byte({n[3:0], a[2:0], 1'b0}, ak);
        exp = (n == 10 && a == int'(STRAP)) ? 1 : 0;
        chk(int'(ak) == exp, "R2", ak, exp);
        bstop();
      end

    bstart(); send_byte(DEVW, ak); send_byte(8'h33, ak); bstop();
    bstart(); send_byte(DEVW, ak); bstop();
    chk(ak, "R7 no busy after address-only write", ak, 1);

    for (int p = 0; p < 32; p++) begin
      okall = 1'b1;
      bstart(); send_byte(DEVW, ak); okall &= ak;
      send_byte(8'(p * 8), ak); okall &= ak;
      for (int i = 0; i < 8; i++) begin
        send_byte(f(p * 8 + i), ak);
        okall &= ak;
      end
      bstop();
      chk(okall, "R1 page fill acks", okall, 1);
      bstart(); send_byte(DEVW, ak); bstop();
      chk(!ak, "R8 busy nack", ak, 0);
      repeat (WRC + 20) @(negedge clk);
      bstart(); send_byte(DEVW, ak); bstop();
      chk(ak, "R7 ack after busy", ak, 1);
    end

    set_ptr_read(8'hFC);
    for (int i = 0; i < 260; i++) begin
      recv_byte(i != 259, d);
      exp = f((252 + i) & 255);
      chk(d == 8'(exp), "R10", d, exp);
    end
    chk(sda_pull == 1'b0, "R4 release after nack", sda_pull, 0);
    bstop();

    bstart(); send_byte(DEVR, ak); recv_byte(1'b0, d); bstop();
    chk(d == f(0), "R11", d, f(0));

    bstart(); send_byte(DEVW, ak); send_byte(8'h45, ak);
    for (int j = 0; j < 5; j++) send_byte(8'hC0 + 8'(j), ak);
    bstop();
    repeat (WRC + 20) @(negedge clk);
    set_ptr_read(8'h40);
    for (int k = 0; k < 8; k++) begin
      recv_byte(k != 7, d);
      exp = ((k + 3) % 8 < 5) ? 32'hC0 + (k + 3) % 8 : int'(f(8'h40 + k));
      chk(d == 8'(exp), "R5", d, exp);
    end
    bstop();

    wp = 1'b1;
    bstart(); send_byte(DEVW, ak); send_byte(8'h10, ak); send_byte(8'hAA, ak); bstop();
    chk(ak, "R6 data acked under wp", ak, 1);
    bstart(); send_byte(DEVW, ak); bstop();
    chk(ak, "R6 no busy under wp", ak, 1);
    wp = 1'b0;
    set_ptr_read(8'h10);
    recv_byte(1'b0, d); bstop();
    chk(d == f(16), "R6 array unchanged", d, f(16));

    chk(r3_viol == 0, "R3 pull changed while clock high", r3_viol, 0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule